// File: doc/BRIEF.md
# Register-Mapped GPIO and Control Bank

This peripheral sits on a simple synchronous register bus. It holds a small set of 16-bit control registers and a 16-line general-purpose port. A bus access is one cycle of `req_i`, qualified by `we_i`. Only address bits 5:0 select a register, so the map repeats every 64 bytes. Write data arrives on a 32-bit bus and only its low half is kept. Read data is registered and appears in the cycle after the read strobe.

The port keeps a direction word and a level word. Software writes the level through either of two aliased offsets, and the write is masked by the current direction. After every write to the direction or level word, the block takes the level word ANDed with the direction word as the effective drive. It moves that value onto the output lines and, for one cycle, raises a change pulse on each line whose drive differs from the previous value.

The input lines are watched for edges. When an input line changes, the block copies its new value into the matching level bit. The output lines are not refreshed by input activity; they follow only on the next direction or level write. A one-cycle error flag marks any access to an offset that is not in the map.

Top module: `ctl_gpio_periph`

## Requirements
- R1: Only `addr_i[5:0]` selects a register. Offsets differing only in bits above 5 reach the same register.
- R2: A write stores only `wdata_i[15:0]`. Reading back any plain register (0x00 mode, 0x04 divider, 0x10 clock control, 0x14 request, 0x18 mask, 0x1C status-of-interrupts) returns that low half.
- R3: A write to the power register at 0x0C stores the data. When data bit 7 is 1, bits 15 and 6 of the stored value are also set (OR 0x8040).
- R4: A write to 0x24 or 0x28 loads the level word with the write data ANDed with the current direction word. The two offsets behave the same.
- R5: Reads of 0x24 and 0x28 both return the level word. A read of 0x20 returns the direction word.
- R6: One cycle after any write to 0x20, 0x24 or 0x28, `pin_out_o` equals the level word ANDed with the direction word. At all other times `pin_out_o` holds its value.
- R7: In the cycle `pin_out_o` is updated, `pin_chg_o` is 1 exactly on the bits where the new drive differs from the previous one. In every other cycle `pin_chg_o` is zero.
- R8: A change on an input line copies its new value into the matching level bit one cycle later. `pin_out_o` does not change as a result.
- R9: The status register at 0x08 reads 0x0002 from reset, and writes to it have no effect.
- R10: A read of an offset outside the map returns zero, and a write to such an offset changes no register. Either access pulses `err_o` for exactly one cycle, in the cycle after the strobe.
- R11: After reset, every register other than status reads zero, and `pin_out_o`, `pin_chg_o` and `err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte address; bits 5:0 decoded |
| wdata_i | input | 32 | Write data; low 16 bits kept |
| rdata_o | output | 16 | Read data, valid the cycle after a read strobe |
| err_o | output | 1 | One-cycle pulse after an access to an unmapped offset |
| pin_in_i | input | 16 | GPIO input lines |
| pin_out_o | output | 16 | GPIO output lines (level AND direction) |
| pin_chg_o | output | 16 | One-cycle per-line change pulse on output update |

## Verification
The bench aims at the masking order around direction changes. Clearing a direction bit has to drop the matching output. A level write that is not masked by direction would show up as a level readback with bits set where the direction is 0. Aliased addresses with high bits set, and offsets just off the word grid, expose a decoder that looks at too many or too few bits: the wrong register changes, or `err_o` stays silent. Power writes with and without bit 7 catch a missing or misplaced force mask. Input edges between writes catch a design that refreshes the outputs on input activity, or one that lets the change pulse linger.

// File: rtl/gpio_periph_pkg.sv
package gpio_periph_pkg;

  localparam int unsigned OFF_W = 6;

  typedef enum logic [OFF_W-1:0] {
    OFF_MODE     = 6'h00,
    OFF_CLKDIV   = 6'h04,
    OFF_STATUS   = 6'h08,
    OFF_POWER    = 6'h0C,
    OFF_CLKCTL   = 6'h10,
    OFF_IRQ_REQ  = 6'h14,
    OFF_IRQ_MASK = 6'h18,
    OFF_IRQ_STAT = 6'h1C,
    OFF_DIR      = 6'h20,
    OFF_LVL_W    = 6'h24,
    OFF_LVL_R    = 6'h28
  } reg_off_e;

  // index of plain read/write registers inside the control bank
  localparam int unsigned NUM_PLAIN = 6;
  localparam int unsigned PL_MODE     = 0;
  localparam int unsigned PL_CLKDIV   = 1;
  localparam int unsigned PL_CLKCTL   = 2;
  localparam int unsigned PL_IRQ_REQ  = 3;
  localparam int unsigned PL_IRQ_MASK = 4;
  localparam int unsigned PL_IRQ_STAT = 5;

  typedef struct packed {
    logic [NUM_PLAIN-1:0] plain;
    logic                 status;
    logic                 power;
    logic                 dir;
    logic                 lvl;
  } reg_sel_t;

endpackage

// File: rtl/periph_addr_dec.sv
module periph_addr_dec
  import gpio_periph_pkg::*;
(
  input  logic [OFF_W-1:0] off_i,
  output reg_sel_t         sel_o,
  output logic             hit_o
);

  always_comb begin
    sel_o = '0;
    unique case (off_i)
      OFF_MODE:     sel_o.plain[PL_MODE]     = 1'b1;
      OFF_CLKDIV:   sel_o.plain[PL_CLKDIV]   = 1'b1;
      OFF_CLKCTL:   sel_o.plain[PL_CLKCTL]   = 1'b1;
      OFF_IRQ_REQ:  sel_o.plain[PL_IRQ_REQ]  = 1'b1;
      OFF_IRQ_MASK: sel_o.plain[PL_IRQ_MASK] = 1'b1;
      OFF_IRQ_STAT: sel_o.plain[PL_IRQ_STAT] = 1'b1;
      OFF_STATUS:   sel_o.status = 1'b1;
      OFF_POWER:    sel_o.power  = 1'b1;
      OFF_DIR:      sel_o.dir    = 1'b1;
      OFF_LVL_W,
      OFF_LVL_R:    sel_o.lvl    = 1'b1;
      default:      sel_o = '0;
    endcase
  end

  assign hit_o = |sel_o;

endmodule

// File: rtl/periph_ctrl_bank.sv
module periph_ctrl_bank
  import gpio_periph_pkg::*;
#(
  parameter int unsigned       REG_W     = 16,
  parameter int unsigned       PWR_TRIG  = 7,
  parameter logic [REG_W-1:0]  PWR_FORCE = 16'h8040
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_i,
  input  reg_sel_t              sel_i,
  input  logic [REG_W-1:0]      wdata_i,
  output logic [REG_W-1:0]      plain_o [NUM_PLAIN],
  output logic [REG_W-1:0]      power_o
);

  for (genvar g = 0; g < NUM_PLAIN; g++) begin : g_plain
    logic [REG_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      q <= '0;
      else if (wr_i && sel_i.plain[g])  q <= wdata_i;
    end
    assign plain_o[g] = q;
  end

  logic [REG_W-1:0] pwr_q;
  logic [REG_W-1:0] pwr_d;

  // trigger bit pulls in the forced bits
  assign pwr_d = wdata_i | (wdata_i[PWR_TRIG] ? PWR_FORCE : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   pwr_q <= '0;
    else if (wr_i && sel_i.power)  pwr_q <= pwr_d;
  end

  assign power_o = pwr_q;

endmodule

// File: rtl/periph_gpio_port.sv
module periph_gpio_port #(
  parameter int unsigned PIN_N = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dir_we_i,
  input  logic             lvl_we_i,
  input  logic [PIN_N-1:0] wdata_i,
  input  logic [PIN_N-1:0] pin_in_i,
  output logic [PIN_N-1:0] dir_o,
  output logic [PIN_N-1:0] lvl_o,
  output logic [PIN_N-1:0] pin_out_o,
  output logic [PIN_N-1:0] pin_chg_o
);

  logic [PIN_N-1:0] dir_q, lvl_q, pin_q, out_q, chg_q;
  logic [PIN_N-1:0] dir_d, lvl_d, lvl_base, pin_evt, eff;
  logic             upd;

  assign pin_evt  = pin_in_i ^ pin_q;
  assign lvl_base = lvl_we_i ? (wdata_i & dir_q) : lvl_q;
  // input edges override the stored bit on the lines that moved
  assign lvl_d    = (lvl_base & ~pin_evt) | (pin_in_i & pin_evt);
  assign dir_d    = dir_we_i ? wdata_i : dir_q;
  assign eff      = lvl_d & dir_d;
  assign upd      = dir_we_i | lvl_we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '0;
      lvl_q <= '0;
      pin_q <= '0;
      out_q <= '0;
      chg_q <= '0;
    end else begin
      dir_q <= dir_d;
      lvl_q <= lvl_d;
      pin_q <= pin_in_i;
      chg_q <= upd ? (eff ^ out_q) : '0;
      if (upd) out_q <= eff;
    end
  end

  assign dir_o     = dir_q;
  assign lvl_o     = lvl_q;
  assign pin_out_o = out_q;
  assign pin_chg_o = chg_q;

endmodule

// File: rtl/ctl_gpio_periph.sv
module ctl_gpio_periph
  import gpio_periph_pkg::*;
#(
  parameter int unsigned      ADDR_W     = 8,
  parameter int unsigned      BUS_W      = 32,
  parameter int unsigned      REG_W      = 16,
  parameter logic [REG_W-1:0] STATUS_RST = 16'h0002,
  parameter int unsigned      PWR_TRIG   = 7,
  parameter logic [REG_W-1:0] PWR_FORCE  = 16'h8040
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              err_o,
  input  logic [REG_W-1:0]  pin_in_i,
  output logic [REG_W-1:0]  pin_out_o,
  output logic [REG_W-1:0]  pin_chg_o
);

  logic [OFF_W-1:0] off;
  logic [REG_W-1:0] wdat;
  logic             unused_hi;

  assign off       = addr_i[OFF_W-1:0];
  assign wdat      = wdata_i[REG_W-1:0];
  assign unused_hi = ^{addr_i[ADDR_W-1:OFF_W], wdata_i[BUS_W-1:REG_W]};

  reg_sel_t sel;
  logic     hit;
  logic     wr;

  periph_addr_dec u_dec (
    .off_i (off),
    .sel_o (sel),
    .hit_o (hit)
  );

  assign wr = req_i & we_i;

  logic [REG_W-1:0] plain [NUM_PLAIN];
  logic [REG_W-1:0] power;

  periph_ctrl_bank #(
    .REG_W     (REG_W),
    .PWR_TRIG  (PWR_TRIG),
    .PWR_FORCE (PWR_FORCE)
  ) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr),
    .sel_i   (sel),
    .wdata_i (wdat),
    .plain_o (plain),
    .power_o (power)
  );

  logic [REG_W-1:0] gpio_dir, gpio_lvl;

  periph_gpio_port #(.PIN_N(REG_W)) u_gpio (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .dir_we_i  (wr & sel.dir),
    .lvl_we_i  (wr & sel.lvl),
    .wdata_i   (wdat),
    .pin_in_i  (pin_in_i),
    .dir_o     (gpio_dir),
    .lvl_o     (gpio_lvl),
    .pin_out_o (pin_out_o),
    .pin_chg_o (pin_chg_o)
  );

  logic [REG_W-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_PLAIN; i++) begin
      if (sel.plain[i]) rd_mux = plain[i];
    end
    if (sel.status) rd_mux = STATUS_RST;
    if (sel.power)  rd_mux = power;
    if (sel.dir)    rd_mux = gpio_dir;
    if (sel.lvl)    rd_mux = gpio_lvl;
  end

  logic [REG_W-1:0] rdata_q;
  logic             err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      if (req_i && !we_i) rdata_q <= rd_mux;
      err_q <= req_i & ~hit;
    end
  end

  assign rdata_o = rdata_q;
  assign err_o   = err_q;

endmodule

// File: rtl/ctl_gpio_periph_chk.sv
module ctl_gpio_periph_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned REG_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [REG_W-1:0]  rdata_o,
  input logic              err_o,
  input logic [REG_W-1:0]  pin_out_o,
  input logic [REG_W-1:0]  pin_chg_o,
  input logic [REG_W-1:0]  gpio_dir
);

  logic [5:0] o;
  logic       mapped, gpio_wr;

  assign o = addr_i[5:0];
  assign mapped = (o[1:0] == 2'b00) && (o <= 6'h28);
  assign gpio_wr = req_i && we_i && (o == 6'h20 || o == 6'h24 || o == 6'h28);

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gpio_wr |=> $stable(pin_out_o)); // R6

  AST_OUT_WITHIN_DIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_out_o & ~gpio_dir) == '0); // R6

  AST_CHG_IS_DELTA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> pin_chg_o == (pin_out_o ^ $past(pin_out_o))); // R7

  AST_CHG_ONLY_AFTER_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gpio_wr |=> pin_chg_o == '0); // R7

  AST_STATUS_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && o == 6'h08) |=> rdata_o == 16'h0002); // R9

  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !mapped) |=> rdata_o == '0); // R10

  AST_ERR_TRACKS_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !mapped) |=> err_o); // R10

  AST_ERR_NO_FALSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !mapped) |=> !err_o); // R10

endmodule

bind ctl_gpio_periph ctl_gpio_periph_chk #(
  .ADDR_W (ADDR_W),
  .REG_W  (REG_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .rdata_o   (rdata_o),
  .err_o     (err_o),
  .pin_out_o (pin_out_o),
  .pin_chg_o (pin_chg_o),
  .gpio_dir  (gpio_dir)
);

// File: tb/ctl_gpio_periph_test.sv
module ctl_gpio_periph_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [15:0] rdata;
  logic        err;
  logic [15:0] pin_in = '0;
  logic [15:0] pin_out, pin_chg;

  always #2 clk = ~clk;

  ctl_gpio_periph uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .err_o(err), .pin_in_i(pin_in),
    .pin_out_o(pin_out), .pin_chg_o(pin_chg)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  // bench model
  logic [15:0] m_plain [6];
  logic [15:0] m_pwr = '0, m_dir = '0, m_lvl = '0, m_out = '0, m_chg = '0;
  logic [15:0] m_pins = '0;

  localparam logic [5:0] PLAIN_OFF [6] = '{6'h00, 6'h04, 6'h10, 6'h14, 6'h18, 6'h1C};

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic mapped(input logic [5:0] o);
    return (o[1:0] == 2'b00) && (o <= 6'h28);
  endfunction

  function automatic logic [15:0] m_read(input logic [5:0] o);
    for (int i = 0; i < 6; i++) if (PLAIN_OFF[i] == o) return m_plain[i];
    case (o)
      6'h08: return 16'h0002;
      6'h0C: return m_pwr;
      6'h20: return m_dir;
      6'h24, 6'h28: return m_lvl;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [15:0] pwr_exp(input logic [15:0] d);
    return d[7] ? (d | 16'h8040) : d;
  endfunction

  task automatic m_write(input logic [5:0] o, input logic [15:0] d);
    logic gp;
    gp = 1'b0;
    for (int i = 0; i < 6; i++) if (PLAIN_OFF[i] == o) m_plain[i] = d;
    case (o)
      6'h0C: m_pwr = pwr_exp(d);
      6'h20: begin m_dir = d; gp = 1'b1; end
      6'h24, 6'h28: begin m_lvl = d & m_dir; gp = 1'b1; end
      default: ;
    endcase
    if (gp) begin
      m_chg = (m_lvl & m_dir) ^ m_out;
      m_out = m_lvl & m_dir;
    end else m_chg = '0;
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d, input string tag);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
    m_write(a[5:0], d[15:0]);
    chk({tag, " pin_out"}, pin_out, m_out);
    chk({tag, " pin_chg"}, pin_chg, m_chg);
    chk({tag, " err"}, {15'b0, err}, {15'b0, !mapped(a[5:0])});
  endtask

  task automatic bus_rd(input logic [7:0] a, input string tag);
    @(negedge clk); req = 1; we = 0; addr = a;
    @(negedge clk); req = 0;
    m_chg = '0;
    chk({tag, " rdata"}, rdata, m_read(a[5:0]));
    chk({tag, " err"}, {15'b0, err}, {15'b0, !mapped(a[5:0])});
  endtask

  task automatic set_pins(input logic [15:0] v, input string tag);
    logic [15:0] ev;
    @(negedge clk); pin_in = v;
    @(negedge clk);
    ev = v ^ m_pins;
    m_lvl = (m_lvl & ~ev) | (v & ev);
    m_pins = v;
    m_chg = '0;
    chk({tag, " pin_out held"}, pin_out, m_out);
    chk({tag, " pin_chg idle"}, pin_chg, 16'h0);
  endtask

  initial begin
    for (int i = 0; i < 6; i++) m_plain[i] = '0;
    #9 rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 pin_out reset", pin_out, 16'h0);
    chk("R11 pin_chg reset", pin_chg, 16'h0);
    chk("R11 err reset", {15'b0, err}, 16'h0);
    for (int i = 0; i < 6; i++) bus_rd({2'b00, PLAIN_OFF[i]}, "R11 plain reset");
    bus_rd(8'h0C, "R11 power reset");
    bus_rd(8'h20, "R11 dir reset");
    bus_rd(8'h24, "R11 lvl reset");
    // R9 status
    bus_rd(8'h08, "R9 status reset");
    bus_wr(8'h08, 32'h0000_FFFF, "R9 status write");
    bus_rd(8'h08, "R9 status after write");
    // R2 low half kept
    bus_wr(8'h00, 32'hDEAD_1234, "R2 mode write");
    bus_rd(8'h00, "R2 mode read");
    bus_wr(8'h1C, 32'hFFFF_A5A5, "R2 irq stat write");
    bus_rd(8'h1C, "R2 irq stat read");
    // R3 power forcing
    bus_wr(8'h0C, 32'h0000_0080, "R3 power trig");
    bus_rd(8'h0C, "R3 power trig read");
    chk("R3 power forced bits", rdata, 16'h80C0);
    bus_wr(8'h0C, 32'h0000_0101, "R3 power no trig");
    bus_rd(8'h0C, "R3 power plain read");
    // R1 aliasing
    bus_wr(8'hC4, 32'h0000_3C3C, "R1 alias write");
    bus_rd(8'h04, "R1 alias read base");
    bus_rd(8'h84, "R1 alias read high");
    // R4/R5/R6/R7 gpio
    bus_wr(8'h24, 32'h0000_FFFF, "R4 lvl with dir zero");
    bus_rd(8'h24, "R4 lvl masked");
    bus_wr(8'h20, 32'h0000_00FF, "R6 dir set");
    bus_wr(8'h28, 32'h0000_F0F0, "R4 lvl via read offset");
    chk("R7 chg pulse", pin_chg, 16'h00F0);
    @(negedge clk); m_chg = '0;
    chk("R7 chg drops", pin_chg, 16'h0);
    bus_rd(8'h24, "R5 lvl via write offset");
    bus_rd(8'h28, "R5 lvl via read offset");
    bus_rd(8'h20, "R5 dir read");
    bus_wr(8'h20, 32'h0000_000F, "R6 dir shrink drops outputs");
    chk("R6 output after shrink", pin_out, 16'h0000);
    // R8 input edges
    set_pins(16'h0F0F, "R8 pins rise");
    bus_rd(8'h24, "R8 lvl after rise");
    set_pins(16'h0F00, "R8 pins fall");
    bus_rd(8'h24, "R8 lvl after fall");
    bus_wr(8'h20, 32'h0000_0F00, "R6 dir picks up pin level");
    // R10 unmapped
    bus_wr(8'h2C, 32'h0000_FFFF, "R10 write unmapped");
    bus_rd(8'h2C, "R10 read unmapped");
    bus_wr(8'h02, 32'h0000_FFFF, "R10 write off-grid");
    bus_rd(8'h00, "R10 mode untouched");
    bus_rd(8'h3C, "R10 read top");
    @(negedge clk);
    chk("R10 err one cycle", {15'b0, err}, 16'h0);

    // random phase
    void'($urandom(32'h5EED_0421));
    for (int k = 0; k < 400; k++) begin
      int op;
      logic [7:0] a;
      op = int'($urandom_range(0, 9));
      if ($urandom_range(0, 4) == 0) a = 8'($urandom);
      else a = {2'($urandom), 6'($urandom_range(0, 10) * 4)};
      if (op < 4)      bus_wr(a, $urandom, "R4 R6 R7 random write");
      else if (op < 8) bus_rd(a, "R5 R10 random read");
      else             set_pins(16'($urandom), "R8 random pins");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule